// File: doc/BRIEF.md
# Two-Stage Watchdog Escalation Controller

This block turns a free-running 64-bit time-base value into a three-step watchdog. It watches a single tap of the time base, chosen by a 6-bit select, and counts each 0-to-1 change of that tap as one expiry. The first expiry only marks the watchdog as armed. The second raises a warning flag, which drives a critical interrupt when both the watchdog interrupt enable and the critical-interrupt enable are set. A third expiry, while both flags are still set, performs the final action. Software avoids the escalation by clearing the flags through a write-1-to-clear port before the next expiry.

The final action is chosen by a 2-bit control field that software can set only once. Its value is either no action, a one-cycle checkstop pulse or a one-cycle reset-request pulse. The control value in force at the final expiry is copied into a cause field. A power-on reset clears the cause field, but a soft reset leaves it alone, so software can read the cause after the soft reset that the reset request provoked.

Top module: `wdog_escalator`

## Requirements
- R1: `tap_sel` value k watches time-base bit 63-k: select 0 is bit 63 (the most significant bit) and select 63 is bit 0. Only a 0-to-1 change of the watched bit between two consecutive clock cycles counts as an expiry. A steady 1 or a falling bit does not count.
- R2: An expiry while the armed flag (`stat_o[3]`) is 0 sets the armed flag and changes nothing else.
- R3: An expiry while armed is 1 and the warning flag (`stat_o[2]`) is 0 sets the warning flag.
- R4: An expiry while armed and warning are both 1 is the final expiry. It copies the current control value into the cause field `stat_o[1:0]` and leaves both flags set.
- R5: At the final expiry, control value 01 produces a one-cycle `chkstop_o` pulse and control value 10 produces a one-cycle `rst_req_o` pulse. Values 00 and 11 produce no pulse. The two pulses never occur together.
- R6: A control write (`rc_wr_en` with `rc_wr_data`) takes effect only while the control value is 00. Once the value is non-zero, writes are ignored until a reset.
- R7: `crit_irq_o` is high exactly when the warning flag, `wdog_irq_en` and `crit_en` are all 1.
- R8: When `clr_wr` is high, each 1 in `clr_mask` clears the matching `stat_o` bit. A 0 in the mask has no effect. An expiry that sets a flag in the same cycle wins over the clear.
- R9: A soft reset (`rst_n` low) clears both flags, the control value and the pulses, and keeps the cause field. A power-on reset (`por_n` low) also clears the cause field.
- R10: After either reset is released, a watched bit that is already 1 does not count as an expiry. Flags and pulses change on the clock edge that follows the cycle in which the watched bit rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous active-low, clears everything |
| rst_n | input | 1 | Soft reset, asynchronous active-low, keeps the cause field |
| tb_val | input | 64 | Time-base value |
| tap_sel | input | 6 | Watched-tap select, 0 = bit 63 |
| rc_wr_en | input | 1 | Write strobe for the control field |
| rc_wr_data | input | 2 | Control value to write (00 none, 01 checkstop, 10 reset request, 11 none) |
| wdog_irq_en | input | 1 | Watchdog interrupt enable |
| crit_en | input | 1 | Critical-interrupt enable |
| clr_wr | input | 1 | Write-1-to-clear strobe for the status |
| clr_mask | input | 4 | Clear mask, same layout as `stat_o` |
| stat_o | output | 4 | {armed, warning, cause[1:0]} |
| rc_o | output | 2 | Current control value |
| crit_irq_o | output | 1 | Critical interrupt request |
| chkstop_o | output | 1 | One-cycle checkstop pulse |
| rst_req_o | output | 1 | One-cycle reset-request pulse |

## Verification
The bench aims at the extreme tap positions 0 and 63. A design that reverses the bit order would arm on the wrong bit, and one that triggers on the level would arm again on every cycle. It attempts to overwrite a locked control value, which a design without the lock would accept. It raises an expiry in the same cycle as a full clear, where a clear-wins design would lose the event. It applies a soft reset after a checkstop, so a design that resets the cause field on soft reset would show 00. It also writes the reserved control value 11, which must produce neither pulse, and it holds the watched bit at 1 across reset release, which must not arm the watchdog.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int TB_W   = 64;
  localparam int SEL_W  = $clog2(TB_W);
  localparam int RC_W   = 2;
  localparam int STAT_W = 2 + RC_W;

  localparam int ST_ARM  = STAT_W - 1;
  localparam int ST_WARN = STAT_W - 2;

  typedef enum logic [RC_W-1:0] {
    RC_NONE  = 2'b00,
    RC_CHK   = 2'b01,
    RC_RSTO  = 2'b10,
    RC_RSVD  = 2'b11
  } rc_e;
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/wdog_tap_edge.sv
module wdog_tap_edge #(
  parameter int TB_W  = 64,
  parameter int SEL_W = $clog2(TB_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TB_W-1:0]  tb_val,
  input  logic [SEL_W-1:0] tap_sel,
  output logic             tmo_o
);
  localparam logic [SEL_W-1:0] TOP_IDX = SEL_W'(TB_W - 1);

  logic [SEL_W-1:0] tap_idx;
  logic             tap_cur;
  logic             prev_q, prev_d;
  logic             primed_q, primed_d;

  always_comb begin
    tap_idx  = TOP_IDX - tap_sel;
    tap_cur  = tb_val[tap_idx];
    prev_d   = tap_cur;
    primed_d = 1'b1;
    tmo_o    = primed_q & tap_cur & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= prev_d;
      primed_q <= primed_d;
    end
  end
endmodule

// File: rtl/wdog_ctrl_lock.sv
module wdog_ctrl_lock
  import wdog_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [RC_W-1:0] wr_data,
  output logic [RC_W-1:0] rc_o
);
  logic [RC_W-1:0] rc_q, rc_d;
  logic            rc_ce;

  always_comb begin
    rc_ce = wr_en && (rc_q == RC_NONE);
    rc_d  = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rc_q <= RC_NONE;
    else if (rc_ce) rc_q <= rc_d;
  end

  assign rc_o = rc_q;
endmodule

// File: rtl/wdog_stage.sv
module wdog_stage
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              soft_rst_n,
  input  logic              por_rst_n,
  input  logic              tmo,
  input  logic [RC_W-1:0]   rc,
  input  logic [STAT_W-1:0] clr,
  output logic              armed_o,
  output logic              warned_o,
  output logic [RC_W-1:0]   cause_o,
  output logic              chkstop_o,
  output logic              rstreq_o
);
  logic            armed_q, armed_d;
  logic            warned_q, warned_d;
  logic [RC_W-1:0] cause_q, cause_d;
  logic            chk_q, chk_d;
  logic            rsr_q, rsr_d;
  logic            final_evt;

  always_comb begin
    final_evt = tmo & armed_q & warned_q;

    if (tmo)                armed_d = 1'b1;
    else if (clr[ST_ARM])   armed_d = 1'b0;
    else                    armed_d = armed_q;

    if (tmo && armed_q)     warned_d = 1'b1;
    else if (clr[ST_WARN])  warned_d = 1'b0;
    else                    warned_d = warned_q;

    if (final_evt) cause_d = rc;
    else           cause_d = cause_q & ~clr[RC_W-1:0];

    chk_d = final_evt && (rc == RC_CHK);
    rsr_d = final_evt && (rc == RC_RSTO);
  end

  always_ff @(posedge clk or negedge soft_rst_n) begin
    if (!soft_rst_n) begin
      armed_q  <= 1'b0;
      warned_q <= 1'b0;
      chk_q    <= 1'b0;
      rsr_q    <= 1'b0;
    end else begin
      armed_q  <= armed_d;
      warned_q <= warned_d;
      chk_q    <= chk_d;
      rsr_q    <= rsr_d;
    end
  end

  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n) cause_q <= RC_NONE;
    else            cause_q <= cause_d;
  end

  assign armed_o   = armed_q;
  assign warned_o  = warned_q;
  assign cause_o   = cause_q;
  assign chkstop_o = chk_q;
  assign rstreq_o  = rsr_q;
endmodule

// File: rtl/wdog_escalator.sv
module wdog_escalator
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic [TB_W-1:0]   tb_val,
  input  logic [SEL_W-1:0]  tap_sel,
  input  logic              rc_wr_en,
  input  logic [RC_W-1:0]   rc_wr_data,
  input  logic              wdog_irq_en,
  input  logic              crit_en,
  input  logic              clr_wr,
  input  logic [STAT_W-1:0] clr_mask,
  output logic [STAT_W-1:0] stat_o,
  output logic [RC_W-1:0]   rc_o,
  output logic              crit_irq_o,
  output logic              chkstop_o,
  output logic              rst_req_o
);
  logic              por_s_n;
  logic              soft_s_n;
  logic              soft_raw_n;
  logic              tmo_evt;
  logic [RC_W-1:0]   rc_q;
  logic [STAT_W-1:0] clr_vec;
  logic              armed, warned;
  logic [RC_W-1:0]   cause;

  assign soft_raw_n = rst_n & por_n;
  assign clr_vec    = clr_wr ? clr_mask : '0;

  wdog_rst_sync u_por_sync (
    .clk    (clk),
    .arst_n (por_n),
    .srst_n (por_s_n)
  );

  wdog_rst_sync u_soft_sync (
    .clk    (clk),
    .arst_n (soft_raw_n),
    .srst_n (soft_s_n)
  );

  wdog_tap_edge #(.TB_W(TB_W), .SEL_W(SEL_W)) u_tap (
    .clk     (clk),
    .rst_n   (soft_s_n),
    .tb_val  (tb_val),
    .tap_sel (tap_sel),
    .tmo_o   (tmo_evt)
  );

  wdog_ctrl_lock u_lock (
    .clk     (clk),
    .rst_n   (soft_s_n),
    .wr_en   (rc_wr_en),
    .wr_data (rc_wr_data),
    .rc_o    (rc_q)
  );

  wdog_stage u_stage (
    .clk        (clk),
    .soft_rst_n (soft_s_n),
    .por_rst_n  (por_s_n),
    .tmo        (tmo_evt),
    .rc         (rc_q),
    .clr        (clr_vec),
    .armed_o    (armed),
    .warned_o   (warned),
    .cause_o    (cause),
    .chkstop_o  (chkstop_o),
    .rstreq_o   (rst_req_o)
  );

  assign stat_o     = {armed, warned, cause};
  assign rc_o       = rc_q;
  assign crit_irq_o = warned & wdog_irq_en & crit_en;
endmodule

// File: rtl/wdog_escalator_chk.sv
module wdog_escalator_chk (
  input logic       clk,
  input logic       soft_n,
  input logic       tmo,
  input logic [3:0] stat,
  input logic [1:0] rc,
  input logic       crit,
  input logic       chk,
  input logic       rsr
);
  assert_arm_needs_event_R2: assert property (@(posedge clk) disable iff (!soft_n)
    $rose(stat[3]) |-> $past(tmo));

  assert_warn_after_arm_R3: assert property (@(posedge clk) disable iff (!soft_n)
    $rose(stat[2]) |-> ($past(tmo) && $past(stat[3])));

  assert_chk_cause_R4: assert property (@(posedge clk) disable iff (!soft_n)
    chk |-> (stat[1:0] == 2'b01));

  assert_rsr_cause_R4: assert property (@(posedge clk) disable iff (!soft_n)
    rsr |-> (stat[1:0] == 2'b10));

  assert_chk_one_cycle_R5: assert property (@(posedge clk) disable iff (!soft_n)
    chk |=> !chk);

  assert_rsr_one_cycle_R5: assert property (@(posedge clk) disable iff (!soft_n)
    rsr |=> !rsr);

  assert_pulses_exclusive_R5: assert property (@(posedge clk) disable iff (!soft_n)
    !(chk && rsr));

  assert_ctrl_locked_R6: assert property (@(posedge clk) disable iff (!soft_n)
    (rc != 2'b00) |=> $stable(rc));

  assert_crit_needs_warn_R7: assert property (@(posedge clk) disable iff (!soft_n)
    crit |-> stat[2]);
endmodule

bind wdog_escalator wdog_escalator_chk u_chk (
  .clk    (clk),
  .soft_n (soft_s_n),
  .tmo    (tmo_evt),
  .stat   (stat_o),
  .rc     (rc_o),
  .crit   (crit_irq_o),
  .chk    (chkstop_o),
  .rsr    (rst_req_o)
);

// File: tb/wdog_escalator_tb.sv
module wdog_escalator_tb;
  logic        clk = 1'b0;
  logic        por_n, rst_n;
  logic [63:0] tb_val;
  logic [5:0]  tap_sel;
  logic        rc_wr_en;
  logic [1:0]  rc_wr_data;
  logic        wdog_irq_en, crit_en, clr_wr;
  logic [3:0]  clr_mask;
  logic [3:0]  stat_o;
  logic [1:0]  rc_o;
  logic        crit_irq_o, chkstop_o, rst_req_o;

  int n_vec = 0;
  int n_bad = 0;

  bit       m_arm, m_warn, m_prev, m_primed, m_chk, m_rsr;
  bit [1:0] m_cause, m_rc;

  always #10 clk = ~clk;

  wdog_escalator u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .tb_val(tb_val), .tap_sel(tap_sel),
    .rc_wr_en(rc_wr_en), .rc_wr_data(rc_wr_data), .wdog_irq_en(wdog_irq_en),
    .crit_en(crit_en), .clr_wr(clr_wr), .clr_mask(clr_mask), .stat_o(stat_o),
    .rc_o(rc_o), .crit_irq_o(crit_irq_o), .chkstop_o(chkstop_o), .rst_req_o(rst_req_o)
  );

  function automatic bit watched(logic [63:0] v, logic [5:0] s);
    return v[63 - int'(s)];
  endfunction

  task automatic cmp(string req, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all();
    cmp("R2 R8 armed flag", 8'(stat_o[3]), 8'(m_arm));
    cmp("R3 R8 warning flag", 8'(stat_o[2]), 8'(m_warn));
    cmp("R4 R8 cause field", 8'(stat_o[1:0]), 8'(m_cause));
    cmp("R5 checkstop pulse", 8'(chkstop_o), 8'(m_chk));
    cmp("R5 reset pulse", 8'(rst_req_o), 8'(m_rsr));
    cmp("R6 control value", 8'(rc_o), 8'(m_rc));
    cmp("R7 critical irq", 8'(crit_irq_o), 8'(m_warn & wdog_irq_en & crit_en));
  endtask

  // One clock: predict from the present inputs, advance, compare.
  task automatic cycle();
    bit cur, ev, fin;
    cur = watched(tb_val, tap_sel);
    ev  = m_primed && cur && !m_prev;
    fin = ev && m_arm && m_warn;
    m_chk = fin && (m_rc == 2'b01);
    m_rsr = fin && (m_rc == 2'b10);
    if (fin) m_cause = m_rc;
    else if (clr_wr) m_cause = m_cause & ~clr_mask[1:0];
    if (ev && m_arm) m_warn = 1'b1;
    else if (clr_wr && clr_mask[2]) m_warn = 1'b0;
    if (ev) m_arm = 1'b1;
    else if (clr_wr && clr_mask[3]) m_arm = 1'b0;
    if (m_rc == 2'b00 && rc_wr_en) m_rc = rc_wr_data;
    m_prev = cur;
    m_primed = 1'b1;
    @(negedge clk);
    check_all();
    rc_wr_en = 1'b0;
    clr_wr   = 1'b0;
  endtask

  task automatic do_reset(bit por, logic [63:0] tb_init);
    tb_val = tb_init;
    rc_wr_en = 1'b0;
    clr_wr = 1'b0;
    rst_n = 1'b0;
    if (por) por_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    por_n = 1'b1;
    repeat (4) @(negedge clk);
    m_arm = 0; m_warn = 0; m_rc = 0; m_chk = 0; m_rsr = 0;
    if (por) m_cause = 0;
    m_primed = 1'b1;
    m_prev = watched(tb_val, tap_sel);
    cmp("R9 status after reset", 8'(stat_o), 8'({m_arm, m_warn, m_cause}));
    cmp("R9 control after reset", 8'(rc_o), 8'(0));
    cmp("R9 pulses after reset", 8'({chkstop_o, rst_req_o}), 8'(0));
  endtask

  // Drive the watched bit low for a cycle, then high for a cycle.
  task automatic fire();
    tb_val[63 - int'(tap_sel)] = 1'b0;
    cycle();
    tb_val[63 - int'(tap_sel)] = 1'b1;
    cycle();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog timeout, bench hung");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    por_n = 1'b1; rst_n = 1'b1; tap_sel = 6'd10;
    wdog_irq_en = 1'b1; crit_en = 1'b1;
    rc_wr_data = 2'b00; clr_mask = 4'h0;

    // R10: watched bit already 1 across reset release is not an expiry
    do_reset(1'b1, 64'h0020_0000_0000_0000);
    cycle();
    cmp("R10 no arm on held bit", 8'(stat_o[3]), 8'(0));

    // R1: select 0 watches bit 63; a level or falling bit does not count
    tap_sel = 6'd0; tb_val = '0; cycle();
    tb_val[63] = 1'b1; cycle();
    cmp("R1 select 0 is bit 63", 8'(stat_o[3]), 8'(1));
    cycle();
    cmp("R1 steady bit no warning", 8'(stat_o[2]), 8'(0));
    tb_val[63] = 1'b0; cycle();
    cmp("R1 falling bit no warning", 8'(stat_o[2]), 8'(0));
    tap_sel = 6'd63; tb_val = '0; cycle();
    tb_val[0] = 1'b1; cycle();
    cmp("R1 select 63 is bit 0", 8'(stat_o[2]), 8'(1));

    // R6: first write locks, second ignored; R5 checkstop at final expiry
    rc_wr_en = 1'b1; rc_wr_data = 2'b01; cycle();
    rc_wr_en = 1'b1; rc_wr_data = 2'b10; cycle();
    cmp("R6 locked control", 8'(rc_o), 8'(2'b01));
    fire();
    cmp("R5 checkstop fired", 8'(chkstop_o), 8'(1));
    cmp("R4 cause checkstop", 8'(stat_o[1:0]), 8'(2'b01));
    cycle();
    cmp("R5 checkstop one cycle", 8'(chkstop_o), 8'(0));

    // R8: zero mask no effect; clear racing an expiry loses
    clr_wr = 1'b1; clr_mask = 4'h0; cycle();
    cmp("R8 zero mask", 8'(stat_o), 8'(4'b1101));
    tb_val[0] = 1'b0; cycle();
    tb_val[0] = 1'b1; clr_wr = 1'b1; clr_mask = 4'b1100; cycle();
    cmp("R8 expiry wins over clear", 8'(stat_o[3:2]), 8'(2'b11));

    // R9: soft reset keeps the cause field
    do_reset(1'b0, 64'h0);
    cmp("R9 cause survives soft reset", 8'(stat_o[1:0]), 8'(2'b01));
    clr_wr = 1'b1; clr_mask = 4'b0011; cycle();

    // R5 reset request
    tap_sel = 6'd20;
    rc_wr_en = 1'b1; rc_wr_data = 2'b10; cycle();
    fire(); fire(); fire();
    cmp("R5 reset request fired", 8'(rst_req_o), 8'(1));
    cycle();

    // R5 reserved value 11: cause 11, no pulse
    do_reset(1'b0, 64'h0);
    rc_wr_en = 1'b1; rc_wr_data = 2'b11; cycle();
    fire(); fire(); fire();
    cmp("R5 reserved no pulse", 8'({chkstop_o, rst_req_o}), 8'(0));
    cmp("R4 cause reserved", 8'(stat_o[1:0]), 8'(2'b11));

    // R7: enables gate the critical interrupt
    wdog_irq_en = 1'b0; cycle();
    cmp("R7 irq disabled", 8'(crit_irq_o), 8'(0));
    wdog_irq_en = 1'b1; crit_en = 1'b0; cycle();
    cmp("R7 crit disabled", 8'(crit_irq_o), 8'(0));

    // R9: power-on reset clears cause
    do_reset(1'b1, 64'h0);
    cmp("R9 cause cleared by power-on", 8'(stat_o[1:0]), 8'(0));

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 499) do_reset(1'b0, {$urandom, $urandom});
      tap_sel     = 6'($urandom_range(0, 63));
      tb_val      = {$urandom, $urandom};
      wdog_irq_en = 1'($urandom);
      crit_en     = 1'($urandom);
      clr_wr      = ($urandom_range(0, 7) == 0);
      clr_mask    = 4'($urandom);
      rc_wr_en    = ($urandom_range(0, 31) == 0);
      rc_wr_data  = 2'($urandom);
      cycle();
    end

    finish_run();
  end
endmodule